// File: doc/BRIEF.md
# Interrupt Message Write Generator

This block turns a set of interrupt input pins into 32-bit memory-write requests. The request format is the one an I/O interrupt controller uses when it delivers interrupts as messages over a processor bus. Each pin has a 64-bit routing entry, written through a simple configuration port. The entry selects the target, the extended target, the delivery mode, the vector, the trigger style and a mask. When a pin asserts, the block builds an address word and a data word from the pin's entry. It then presents them on a valid/ready request port.

Pins can be edge or level sensitive. An edge pin fires once for each rising transition. A level pin fires on its rising transition. It fires again when an end-of-interrupt notice carrying its vector arrives while the pin is still high. The block never emits entries whose delivery mode selects a system-management, non-maskable or init interrupt. It records such attempts in a sticky error flag. One request is outstanding at a time. Among pending pins, the lowest-numbered pin is served first.

Top module: `irq_msgwr_gen`

## Requirements
- R1: After reset, `req_valid` and `mode_err` are 0, and every routing entry reads as masked, so no pin produces a request until its entry is rewritten.
- R2: For an edge entry (bit 15 = 0), each 0-to-1 transition of the unmasked pin produces exactly one request. A pin held high produces no further requests.
- R3: For a level entry (bit 15 = 1), the rising transition produces a request. An end-of-interrupt notice whose vector equals entry bits 7:0 produces another request if the pin is high at that time. The notice produces nothing if the pin is low, if the vector differs, or if the entry is an edge entry.
- R4: Routing entry layout is: bits 63:56 destination, bits 55:48 extended destination, bit 16 mask, bit 15 trigger, bit 11 destination mode, bits 10:8 delivery mode, bits 7:0 vector. Request address bits 31:20 are 0xFEE, bits 19:12 are the destination, bits 11:4 are the extended destination, and bits 1:0 are 00.
- R5: Address bit 3 is 1 exactly when the delivery mode is 001 (lowest priority).
- R6: Address bit 2 equals entry bit 11 when address bit 3 is 1. Otherwise it is 0.
- R7: The data word holds the vector in bits 7:0, the delivery mode in bits 10:8 and the trigger bit in bit 15. All other data bits are 0.
- R8: A masked pin produces no request. A request already pending for a pin is discarded when that pin becomes masked.
- R9: Entries with delivery mode 010, 100 or 101 never produce a request. An assert condition on such an unmasked pin sets `mode_err`, which stays set until reset.
- R10: When several pins are pending, requests are issued in increasing pin order.
- R11: While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_addr` and `req_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pins | input | NUM_PINS | Interrupt input pins |
| cfg_we | input | 1 | Routing entry write strobe |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_data | input | 64 | Routing entry value |
| eoi_valid | input | 1 | End-of-interrupt notice strobe |
| eoi_vector | input | 8 | Vector carried by the notice |
| req_valid | output | 1 | Write request valid |
| req_ready | input | 1 | Write request accepted |
| req_addr | output | 32 | Message address word |
| req_data | output | 32 | Message data word |
| mode_err | output | 1 | Sticky refused-delivery-mode flag |

## Verification
On every cycle, the assertions check the fixed address bits and the hint/destination-mode relation between the address and data words. They also check the zero bits of the data word, that no refused mode ever appears in a request, that the error flag stays set, and that an unaccepted request holds steady. Only the bench scenarios can show the following: one request per edge, resends on matching end-of-interrupt notices, discarding under mask, lowest-pin-first ordering, and the exact field placement for a range of routing entries.

// File: rtl/irqmsg_pkg.sv
package irqmsg_pkg;

  localparam int ENTRY_W = 64;
  localparam int WORD_W  = 32;
  localparam int VEC_W   = 8;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'b000,
    DM_LOWPRI = 3'b001,
    DM_SMI    = 3'b010,
    DM_RSV3   = 3'b011,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_RSV6   = 3'b110,
    DM_EXTINT = 3'b111
  } dmode_e;

  // Compact form of the fields the block actually uses
  typedef struct packed {
    logic [7:0]       dest;
    logic [7:0]       xdest;
    logic             mask;
    logic             level;
    logic             logical;
    dmode_e           mode;
    logic [VEC_W-1:0] vec;
  } route_t;

  localparam route_t ROUTE_RESET = '{dest: 8'h00, xdest: 8'h00, mask: 1'b1,
                                     level: 1'b0, logical: 1'b0,
                                     mode: DM_FIXED, vec: '0};

  function automatic route_t unpack_entry(input logic [ENTRY_W-1:0] raw);
    route_t r;
    r.dest    = raw[63:56];
    r.xdest   = raw[55:48];
    r.mask    = raw[16];
    r.level   = raw[15];
    r.logical = raw[11];
    r.mode    = dmode_e'(raw[10:8]);
    r.vec     = raw[7:0];
    return r;
  endfunction

  function automatic logic mode_refused(input dmode_e m);
    return (m == DM_SMI) || (m == DM_NMI) || (m == DM_INIT);
  endfunction

  function automatic logic [WORD_W-1:0] build_addr(input route_t r);
    logic hint;
    hint = (r.mode == DM_LOWPRI);
    return {12'hFEE, r.dest, r.xdest, hint, hint & r.logical, 2'b00};
  endfunction

  function automatic logic [WORD_W-1:0] build_data(input route_t r);
    return {16'h0000, r.level, 4'h0, r.mode, r.vec};
  endfunction

endpackage

// File: rtl/irqmsg_route_tbl.sv
module irqmsg_route_tbl
  import irqmsg_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [ENTRY_W-1:0]   wr_raw,
  output route_t               routes [NUM_PINS]
);

  route_t store [NUM_PINS];
  route_t wr_route;

  always_comb wr_route = unpack_entry(wr_raw);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PINS; i++) store[i] <= ROUTE_RESET;
    end else if (wr_en && (int'(wr_idx) < NUM_PINS)) begin
      store[wr_idx] <= wr_route;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) routes[i] = store[i];
  end

endmodule

// File: rtl/irqmsg_pin_ctl.sv
module irqmsg_pin_ctl
  import irqmsg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_now,
  input  logic             pin_prev,
  input  logic             mask,
  input  logic             level,
  input  dmode_e           mode,
  input  logic [VEC_W-1:0] vec,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  input  logic             grant,
  output logic             pend,
  output logic             bad_hit
);

  logic rise;
  logic eoi_hit;
  logic fire;
  logic refused;

  always_comb begin
    rise    = pin_now & ~pin_prev;
    eoi_hit = eoi_valid & level & (eoi_vector == vec) & pin_now;
    fire    = rise | eoi_hit;
    refused = mode_refused(mode);
    bad_hit = fire & ~mask & refused;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
    end else if (mask || refused) begin
      pend <= 1'b0;
    end else begin
      pend <= (pend & ~grant) | fire;
    end
  end

endmodule

// File: rtl/irqmsg_req_out.sv
module irqmsg_req_out
  import irqmsg_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pend,
  input  route_t              routes [NUM_PINS],
  input  logic                req_ready,
  output logic [NUM_PINS-1:0] grant,
  output logic                req_valid,
  output logic [WORD_W-1:0]   req_addr,
  output logic [WORD_W-1:0]   req_data
);

  logic   any_pend;
  route_t pick;

  // Lowest-numbered pending pin wins
  always_comb begin
    grant    = '0;
    pick     = routes[0];
    any_pend = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (pend[i] && !any_pend) begin
        any_pend = 1'b1;
        pick     = routes[i];
        if (!req_valid) grant[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_data  <= '0;
    end else if (!req_valid) begin
      if (any_pend) begin
        req_valid <= 1'b1;
        req_addr  <= build_addr(pick);
        req_data  <= build_data(pick);
      end
    end else if (req_ready) begin
      req_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_msgwr_gen.sv
module irq_msgwr_gen
  import irqmsg_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_pins,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [63:0]         cfg_data,
  input  logic                eoi_valid,
  input  logic [7:0]          eoi_vector,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [31:0]         req_addr,
  output logic [31:0]         req_data,
  output logic                mode_err
);

  route_t              routes [NUM_PINS];
  logic [NUM_PINS-1:0] pins_q;
  logic [NUM_PINS-1:0] pend;
  logic [NUM_PINS-1:0] grant;
  logic [NUM_PINS-1:0] bad_hit;

  irqmsg_route_tbl #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_tbl (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_we),
    .wr_idx (cfg_idx),
    .wr_raw (cfg_data),
    .routes (routes)
  );

  always_ff @(posedge clk) begin
    if (rst) pins_q <= '0;
    else     pins_q <= irq_pins;
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    irqmsg_pin_ctl u_pin (
      .clk        (clk),
      .rst        (rst),
      .pin_now    (irq_pins[g]),
      .pin_prev   (pins_q[g]),
      .mask       (routes[g].mask),
      .level      (routes[g].level),
      .mode       (routes[g].mode),
      .vec        (routes[g].vec),
      .eoi_valid  (eoi_valid),
      .eoi_vector (eoi_vector),
      .grant      (grant[g]),
      .pend       (pend[g]),
      .bad_hit    (bad_hit[g])
    );
  end

  irqmsg_req_out #(.NUM_PINS(NUM_PINS)) u_out (
    .clk       (clk),
    .rst       (rst),
    .pend      (pend),
    .routes    (routes),
    .req_ready (req_ready),
    .grant     (grant),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_data  (req_data)
  );

  always_ff @(posedge clk) begin
    if (rst)           mode_err <= 1'b0;
    else if (|bad_hit) mode_err <= 1'b1;
  end

endmodule

// File: rtl/irq_msgwr_gen_chk.sv
module irq_msgwr_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic [31:0] req_data,
  input logic        mode_err
);

  // R11
  hold_until_ready_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_data));

  // R4
  addr_fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_addr[31:20] == 12'hFEE) && (req_addr[1:0] == 2'b00));

  // R5
  hint_matches_mode_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_addr[3] == (req_data[10:8] == 3'b001));

  // R6
  dest_mode_gated_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_addr[3] |-> !req_addr[2]);

  // R7
  data_zero_bits_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_data[31:16] == 16'h0) && (req_data[14:11] == 4'h0));

  // R9
  no_refused_mode_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !(req_data[10:8] inside {3'b010, 3'b100, 3'b101}));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    mode_err |=> mode_err);

endmodule

bind irq_msgwr_gen irq_msgwr_gen_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_data  (req_data),
  .mode_err  (mode_err)
);

// File: tb/irq_msgwr_gen_bench.sv
module irq_msgwr_gen_bench;

  localparam int NP = 4;
  localparam int NV = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] irq_pins = '0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_idx = '0;
  logic [63:0]   cfg_data = '0;
  logic          eoi_valid = 1'b0;
  logic [7:0]    eoi_vector = '0;
  logic          req_valid;
  logic          req_ready = 1'b0;
  logic [31:0]   req_addr;
  logic [31:0]   req_data;
  logic          mode_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  irq_msgwr_gen #(.NUM_PINS(NP)) u_irq_msgwr_gen (
    .clk(clk), .rst(rst), .irq_pins(irq_pins), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .eoi_valid(eoi_valid),
    .eoi_vector(eoi_vector), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .mode_err(mode_err)
  );

  // Vector table: pin, entry, expected address, expected data (R4..R7)
  localparam int          V_PIN  [NV] = '{0, 1, 2, 3, 0, 1};
  localparam logic [63:0] V_ENT  [NV] = '{64'h1234_0000_0000_0041, 64'hA50F_0000_0000_0952,
                                         64'h3C00_0000_0000_0160, 64'hFFFF_0000_0000_087E,
                                         64'h0102_0000_0000_0799, 64'h8000_0000_0000_8320};
  localparam logic [31:0] V_ADDR [NV] = '{32'hFEE12340, 32'hFEEA50FC, 32'hFEE3C008,
                                         32'hFEEFFFF0, 32'hFEE01020, 32'hFEE80000};
  localparam logic [31:0] V_DATA [NV] = '{32'h00000041, 32'h00000152, 32'h00000160,
                                         32'h0000007E, 32'h00000799, 32'h00008320};

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int idx, input logic [63:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_data = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_eoi(input logic [7:0] v);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic expect_msg(input logic [31:0] ea, input logic [31:0] ed, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (req_valid) seen = 1'b1;
    end
    check(seen, {tag, " request missing"}, {31'd0, seen}, 32'd1);
    if (seen) begin
      check(req_addr == ea, {tag, " addr"}, req_addr, ea);
      check(req_data == ed, {tag, " data"}, req_data, ed);
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
    end
  endtask

  task automatic expect_none(input int cycles, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (req_valid) seen = 1'b1;
    end
    check(!seen, tag, {31'd0, seen}, 32'd0);
    if (seen) begin
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] held_addr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(req_valid == 1'b0, "R1 req_valid after reset", {31'd0, req_valid}, 32'd0);
    check(mode_err == 1'b0, "R1 mode_err after reset", {31'd0, mode_err}, 32'd0);
    irq_pins[0] = 1'b1;
    expect_none(10, "R1 entries masked after reset");
    irq_pins[0] = 1'b0;

    // Vector walk: R4 R5 R6 R7 R2
    for (int v = 0; v < NV; v++) begin
      cfg_write(V_PIN[v], V_ENT[v]);
      @(negedge clk);
      irq_pins[V_PIN[v]] = 1'b1;
      expect_msg(V_ADDR[v], V_DATA[v], $sformatf("R4/R5/R6/R7 vector %0d", v));
      @(negedge clk);
      irq_pins[V_PIN[v]] = 1'b0;
    end
    check(mode_err == 1'b0, "R9 no error for legal modes", {31'd0, mode_err}, 32'd0);

    // R2: held high gives one request; EOI on edge entry does nothing (R3)
    cfg_write(0, V_ENT[0]);
    irq_pins[0] = 1'b1;
    expect_msg(V_ADDR[0], V_DATA[0], "R2 single edge");
    expect_none(10, "R2 pin held high");
    send_eoi(8'h41);
    expect_none(10, "R3 EOI ignored by edge entry");
    irq_pins[0] = 1'b0;

    // R3: level resend
    cfg_write(3, 64'h0500_0000_0000_8033);
    irq_pins[3] = 1'b1;
    expect_msg(32'hFEE05000, 32'h00008033, "R3 level first assert");
    send_eoi(8'h33);
    expect_msg(32'hFEE05000, 32'h00008033, "R3 resend on EOI while high");
    send_eoi(8'h34);
    expect_none(10, "R3 mismatched vector");
    @(negedge clk);
    irq_pins[3] = 1'b0;
    send_eoi(8'h33);
    expect_none(10, "R3 EOI with pin low");

    // R10: priority; pin1 holds V5 entry, pin2 holds V2 entry
    @(negedge clk);
    irq_pins[2] = 1'b1; irq_pins[1] = 1'b1;
    expect_msg(V_ADDR[5], V_DATA[5], "R10 lower pin first");
    expect_msg(V_ADDR[2], V_DATA[2], "R10 higher pin second");
    irq_pins[2] = 1'b0; irq_pins[1] = 1'b0;

    // R11 hold and R8 discard while masked
    @(negedge clk);
    irq_pins[0] = 1'b1; irq_pins[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    held_addr = req_addr;
    check(req_valid == 1'b1, "R11 valid raised", {31'd0, req_valid}, 32'd1);
    repeat (3) @(negedge clk);
    check(req_valid == 1'b1, "R11 valid held without ready", {31'd0, req_valid}, 32'd1);
    check(req_addr == held_addr, "R11 addr held", req_addr, held_addr);
    cfg_write(2, V_ENT[2] | 64'h1_0000);
    expect_msg(V_ADDR[0], V_DATA[0], "R11 held request delivered");
    cfg_write(2, V_ENT[2]);
    expect_none(10, "R8 pending discarded by mask");
    irq_pins[0] = 1'b0; irq_pins[2] = 1'b0;

    // R9: refused modes
    cfg_write(0, 64'h0100_0000_0000_0244);
    irq_pins[0] = 1'b1;
    expect_none(10, "R9 mode 010 refused");
    check(mode_err == 1'b1, "R9 error set", {31'd0, mode_err}, 32'd1);
    irq_pins[0] = 1'b0;
    cfg_write(0, 64'h0100_0000_0000_0444);
    irq_pins[0] = 1'b1;
    expect_none(10, "R9 mode 100 refused");
    irq_pins[0] = 1'b0;
    cfg_write(0, 64'h0100_0000_0000_0544);
    irq_pins[0] = 1'b1;
    expect_none(10, "R9 mode 101 refused");
    irq_pins[0] = 1'b0;
    cfg_write(0, V_ENT[0]);
    repeat (5) @(negedge clk);
    check(mode_err == 1'b1, "R9 error sticky", {31'd0, mode_err}, 32'd1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule